// File: doc/BRIEF.md
# Clock output gating and frequency select controller

This block is the control logic of a multi-output clock generator. At the release of power-on reset it captures a 4-bit frequency strap code and a mode strap from pins that are shared with clock outputs. From then on the captured values are held and the pins may be driven as clocks. A software control byte chooses whether the synthesizer gets the captured strap code or a software code. The software code is gathered from scattered bits of that byte. A new code is passed to the synthesizer interface only after it has been stable for two consecutive samples.

Each clock output (CPU pair and chipset, PCI, SDRAM in groups, USB 48 MHz, a shared 24/48 MHz pin, and two reference clocks) is gated from its own free-running source. The gate uses a per-output enable, the CPU-stop input (valid only in mode 0) and the power-down input. The enable of each gate is reloaded only on the falling edge of its own source clock. As a result a stopping output always finishes its current high phase and then rests low, and a restarting output never begins with a runt pulse.

Top module: `clkgen_ctrl`

## Requirements
- R1: The strap code `strap_fs_i` and `strap_mode_i` are captured at the first rising `clk_i` edge after `rst_ni` is released, and later changes on the strap pins have no effect on `freq_code_o` or `mode_o`.
- R2: When `freq_ctl_i[3]` is 0 the selected code is the captured strap code. When it is 1 the selected code is `{freq_ctl_i[2], freq_ctl_i[6:4]}`, with bit 2 as the code's MSB.
- R3: `freq_code_o` takes a new value only after the selected code has held that value at two consecutive rising edges of `clk_i`. A change applied before edge a appears after edge a+1. A selection that lasts a single cycle never reaches the output.
- R4: Each output runs when its enable bit is 1 and stops low when it is 0. The enable bits are `cpu_en_i` (CPU and chipset), `pci_en_i[n]`, `sdram_en_i[g]` (group g = outputs 4g..4g+3), `usb_en_i`, `mid_en_i` and `ref_en_i[n]`.
- R5: In mode 0, `cpu_stop_ni` low holds the CPU and chipset outputs low and leaves the other outputs running. In mode 1, `cpu_stop_ni` is ignored.
- R6: In mode 0, `ref_clk_o[0]` is held low and `ref0_oe_o` is 0, because the pin is the CPU-stop input. In mode 1, `ref0_oe_o` is 1 and `ref_clk_o[0]` follows `ref_en_i[0]`.
- R7: `pd_ni` low stops every clock output low.
- R8: No output high pulse is shorter than the high phase of its source. A stop requested during a high phase lets that phase complete.
- R9: `sel48_i` = 1 puts the 48 MHz source on `mid_clk_o`, and `sel48_i` = 0 puts the 24 MHz source there.
- R10: `strap_oe_o` is 0 during reset and until the straps are captured. After that it is 1 and stays 1.
- R11: During reset every clock output is low, `freq_code_o` is 0 and `mode_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Control clock for strap capture and code selection |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| strap_fs_i | input | 4 | Frequency strap code from shared pins |
| strap_mode_i | input | 1 | Mode strap from shared pin |
| freq_ctl_i | input | 8 | Frequency control byte: bit 3 source select, bits 6:4 and 2 software code |
| cpu_en_i | input | 1 | Enable for CPU and chipset clocks |
| pci_en_i | input | NUM_PCI | Per-output PCI enables |
| sdram_en_i | input | NUM_SDG | Per-group SDRAM enables |
| usb_en_i | input | 1 | Enable for 48 MHz USB clock |
| mid_en_i | input | 1 | Enable for shared 24/48 MHz output |
| sel48_i | input | 1 | Shared output select: 1 = 48 MHz, 0 = 24 MHz |
| ref_en_i | input | 2 | Reference clock enables |
| cpu_stop_ni | input | 1 | Active-low CPU clock stop, mode 0 only |
| pd_ni | input | 1 | Active-low power down |
| cpu_src_i | input | 1 | Free-running CPU source clock |
| pci_src_i | input | 1 | Free-running PCI source clock |
| sdram_src_i | input | 1 | SDRAM fanout source clock |
| ref_src_i | input | 1 | Reference source clock |
| clk48_src_i | input | 1 | 48 MHz source clock |
| clk24_src_i | input | 1 | 24 MHz source clock |
| cpu_clk_o | output | 1 | Gated CPU clock |
| chipset_clk_o | output | 1 | Gated chipset clock |
| pci_clk_o | output | NUM_PCI | Gated PCI clocks |
| sdram_clk_o | output | NUM_SDG*SD_PER_GRP | Gated SDRAM clocks |
| usb_clk_o | output | 1 | Gated 48 MHz clock |
| mid_clk_o | output | 1 | Gated shared 24/48 MHz clock |
| ref_clk_o | output | 2 | Gated reference clocks |
| freq_code_o | output | 4 | Qualified frequency code to synthesizer |
| mode_o | output | 1 | Captured mode strap |
| strap_oe_o | output | 1 | Output enable for strap-shared pins |
| ref0_oe_o | output | 1 | Output enable for the REF0/CPU-stop pin |

## Verification
The gating properties assume that enables, `cpu_stop_ni` and `pd_ni` never change exactly at an edge of a source clock. The bench meets this by starting every source a quarter nanosecond off the integer grid on which all inputs change. The code-qualification property assumes the control byte is sampled only by `clk_i`, so the bench changes it on falling `clk_i` edges. The strap properties assume the straps matter only until the first edge after reset. The bench keeps each strap value steady across reset release and changes the straps only after capture, to show they are then ignored.

// File: rtl/clkgen_ctrl_pkg.sv
`timescale 1ns/1ps
package clkgen_ctrl_pkg;
  localparam int FS_W       = 4;
  localparam int CTL_W      = 8;
  localparam int SW_SEL_BIT = 3;

  // software code: MSB from bit 2, low bits from bits 6:4
  function automatic logic [FS_W-1:0] sw_code(input logic [CTL_W-1:0] ctl);
    return {ctl[2], ctl[6:4]};
  endfunction
endpackage

// File: rtl/strap_capture.sv
`timescale 1ns/1ps
module strap_capture #(
  parameter int FS_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [FS_W-1:0] strap_fs_i,
  input  logic            strap_mode_i,
  output logic [FS_W-1:0] fs_o,
  output logic            mode_o,
  output logic            done_o
);
  logic [FS_W-1:0] fs_q;
  logic            mode_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fs_q   <= '0;
      mode_q <= 1'b0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      fs_q   <= strap_fs_i;
      mode_q <= strap_mode_i;
      done_q <= 1'b1;
    end
  end

  assign fs_o   = fs_q;
  assign mode_o = mode_q;
  assign done_o = done_q;
endmodule

// File: rtl/freq_code_sel.sv
`timescale 1ns/1ps
module freq_code_sel
  import clkgen_ctrl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [FS_W-1:0]  strap_fs_i,
  input  logic [CTL_W-1:0] ctl_i,
  output logic [FS_W-1:0]  sel_o,
  output logic [FS_W-1:0]  code_o
);
  logic [FS_W-1:0] sel, pend_q, code_q;
  logic            unused_ctl;

  assign unused_ctl = ^{ctl_i[7], ctl_i[1:0]};
  assign sel = ctl_i[SW_SEL_BIT] ? sw_code(ctl_i) : strap_fs_i;

  // forward only a code seen at two consecutive edges
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      code_q <= '0;
    end else begin
      pend_q <= sel;
      if (pend_q == sel) code_q <= pend_q;
    end
  end

  assign sel_o  = sel;
  assign code_o = code_q;
endmodule

// File: rtl/clk_gate_cell.sv
`timescale 1ns/1ps
module clk_gate_cell (
  input  logic src_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic clk_o
);
  logic en_q;

  // reload only while the source is low: no runt, high phase never cut
  always_ff @(negedge src_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= en_i;
  end

  assign clk_o = src_i & en_q;
endmodule

// File: rtl/clkgen_ctrl.sv
`timescale 1ns/1ps
module clkgen_ctrl
  import clkgen_ctrl_pkg::*;
#(
  parameter int NUM_PCI    = 6,
  parameter int NUM_SDG    = 3,
  parameter int SD_PER_GRP = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [3:0]                    strap_fs_i,
  input  logic                          strap_mode_i,
  input  logic [7:0]                    freq_ctl_i,
  input  logic                          cpu_en_i,
  input  logic [NUM_PCI-1:0]            pci_en_i,
  input  logic [NUM_SDG-1:0]            sdram_en_i,
  input  logic                          usb_en_i,
  input  logic                          mid_en_i,
  input  logic                          sel48_i,
  input  logic [1:0]                    ref_en_i,
  input  logic                          cpu_stop_ni,
  input  logic                          pd_ni,
  input  logic                          cpu_src_i,
  input  logic                          pci_src_i,
  input  logic                          sdram_src_i,
  input  logic                          ref_src_i,
  input  logic                          clk48_src_i,
  input  logic                          clk24_src_i,
  output logic                          cpu_clk_o,
  output logic                          chipset_clk_o,
  output logic [NUM_PCI-1:0]            pci_clk_o,
  output logic [NUM_SDG*SD_PER_GRP-1:0] sdram_clk_o,
  output logic                          usb_clk_o,
  output logic                          mid_clk_o,
  output logic [1:0]                    ref_clk_o,
  output logic [3:0]                    freq_code_o,
  output logic                          mode_o,
  output logic                          strap_oe_o,
  output logic                          ref0_oe_o
);
  localparam int NUM_SD = NUM_SDG * SD_PER_GRP;

  logic [FS_W-1:0] strap_fs_q, sel_code;
  logic            mode_q, strap_done;
  logic            cpu_run, mid24, mid48;

  strap_capture #(.FS_W(FS_W)) i_strap (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .strap_fs_i  (strap_fs_i),
    .strap_mode_i(strap_mode_i),
    .fs_o        (strap_fs_q),
    .mode_o      (mode_q),
    .done_o      (strap_done)
  );

  freq_code_sel i_fsel (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .strap_fs_i(strap_fs_q),
    .ctl_i     (freq_ctl_i),
    .sel_o     (sel_code),
    .code_o    (freq_code_o)
  );

  // CPU stop is honoured only when the shared pin is an input (mode 0)
  assign cpu_run = pd_ni & cpu_en_i & (mode_q | cpu_stop_ni);

  clk_gate_cell i_g_cpu (.src_i(cpu_src_i), .rst_ni(rst_ni), .en_i(cpu_run), .clk_o(cpu_clk_o));
  clk_gate_cell i_g_cs  (.src_i(cpu_src_i), .rst_ni(rst_ni), .en_i(cpu_run), .clk_o(chipset_clk_o));

  for (genvar p = 0; p < NUM_PCI; p++) begin : g_pci
    clk_gate_cell i_g (.src_i(pci_src_i), .rst_ni(rst_ni),
                       .en_i(pd_ni & pci_en_i[p]), .clk_o(pci_clk_o[p]));
  end

  for (genvar s = 0; s < NUM_SD; s++) begin : g_sd
    clk_gate_cell i_g (.src_i(sdram_src_i), .rst_ni(rst_ni),
                       .en_i(pd_ni & sdram_en_i[s / SD_PER_GRP]), .clk_o(sdram_clk_o[s]));
  end

  clk_gate_cell i_g_usb (.src_i(clk48_src_i), .rst_ni(rst_ni),
                         .en_i(pd_ni & usb_en_i), .clk_o(usb_clk_o));

  // shared pin: two gates, each drains its own high phase before handing over
  clk_gate_cell i_g_m24 (.src_i(clk24_src_i), .rst_ni(rst_ni),
                         .en_i(pd_ni & mid_en_i & ~sel48_i), .clk_o(mid24));
  clk_gate_cell i_g_m48 (.src_i(clk48_src_i), .rst_ni(rst_ni),
                         .en_i(pd_ni & mid_en_i & sel48_i), .clk_o(mid48));
  assign mid_clk_o = mid24 | mid48;

  clk_gate_cell i_g_ref0 (.src_i(ref_src_i), .rst_ni(rst_ni),
                          .en_i(pd_ni & ref_en_i[0] & mode_q), .clk_o(ref_clk_o[0]));
  clk_gate_cell i_g_ref1 (.src_i(ref_src_i), .rst_ni(rst_ni),
                          .en_i(pd_ni & ref_en_i[1]), .clk_o(ref_clk_o[1]));

  assign mode_o     = mode_q;
  assign strap_oe_o = strap_done;
  assign ref0_oe_o  = strap_done & mode_q;
endmodule

// File: rtl/clkgen_ctrl_chk.sv
`timescale 1ns/1ps
module clkgen_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pd_ni,
  input logic       cpu_stop_ni,
  input logic       cpu_en_i,
  input logic       mode_o,
  input logic       strap_oe_o,
  input logic       cpu_src_i,
  input logic       cpu_clk_o,
  input logic       pci_src_i,
  input logic       pci0_clk_i,
  input logic       ref_src_i,
  input logic       ref0_clk_i,
  input logic [3:0] sel_code,
  input logic [3:0] freq_code_o
);
  p_code_settled_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freq_code_o != $past(freq_code_o)) |->
      (($past(sel_code, 1) == freq_code_o) && ($past(sel_code, 2) == freq_code_o)));

  p_mode_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strap_oe_o |=> $stable(mode_o));

  p_oe_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strap_oe_o |=> strap_oe_o);

  p_pd_cpu_r7: assert property (@(negedge cpu_src_i) disable iff (!rst_ni)
    !pd_ni |=> !cpu_clk_o);

  p_pd_pci_r7: assert property (@(negedge pci_src_i) disable iff (!rst_ni)
    !pd_ni |=> !pci0_clk_i);

  p_cpu_halt_r5: assert property (@(negedge cpu_src_i) disable iff (!rst_ni)
    (!mode_o && !cpu_stop_ni) |=> !cpu_clk_o);

  p_cpu_run_r4: assert property (@(negedge cpu_src_i) disable iff (!rst_ni)
    (pd_ni && cpu_en_i && (mode_o || cpu_stop_ni)) |=> cpu_clk_o);

  p_ref0_off_r6: assert property (@(negedge ref_src_i) disable iff (!rst_ni)
    !mode_o |=> !ref0_clk_i);
endmodule

bind clkgen_ctrl clkgen_ctrl_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pd_ni      (pd_ni),
  .cpu_stop_ni(cpu_stop_ni),
  .cpu_en_i   (cpu_en_i),
  .mode_o     (mode_o),
  .strap_oe_o (strap_oe_o),
  .cpu_src_i  (cpu_src_i),
  .cpu_clk_o  (cpu_clk_o),
  .pci_src_i  (pci_src_i),
  .pci0_clk_i (pci_clk_o[0]),
  .ref_src_i  (ref_src_i),
  .ref0_clk_i (ref_clk_o[0]),
  .sel_code   (sel_code),
  .freq_code_o(freq_code_o)
);

// File: tb/test_clkgen_ctrl.sv
`timescale 1ns/1ps
module test_clkgen_ctrl;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic [3:0]  strap_fs_i = 4'b1010;
  logic        strap_mode_i = 1'b0;
  logic [7:0]  freq_ctl_i = 8'h00;
  logic        cpu_en_i = 1'b1;
  logic [5:0]  pci_en_i = 6'h3f;
  logic [2:0]  sdram_en_i = 3'h7;
  logic        usb_en_i = 1'b1, mid_en_i = 1'b1, sel48_i = 1'b0;
  logic [1:0]  ref_en_i = 2'b11;
  logic        cpu_stop_ni = 1'b1, pd_ni = 1'b1;
  logic        cpu_src_i = 0, pci_src_i = 0, sdram_src_i = 0, ref_src_i = 0;
  logic        clk48_src_i = 0, clk24_src_i = 0;
  logic        cpu_clk_o, chipset_clk_o, usb_clk_o, mid_clk_o;
  logic [5:0]  pci_clk_o;
  logic [11:0] sdram_clk_o;
  logic [1:0]  ref_clk_o;
  logic [3:0]  freq_code_o;
  logic        mode_o, strap_oe_o, ref0_oe_o;

  int n_chk = 0, n_err = 0, runt = 0, mid_cnt = 0;
  realtime t_cpu_r = 0.0, t_pci_r = 0.0;

  clkgen_ctrl i_clkgen_ctrl (.*);

  always #2.5 clk_i = ~clk_i;
  initial begin #0.25; forever #2  cpu_src_i   = ~cpu_src_i;   end
  initial begin #0.25; forever #6  pci_src_i   = ~pci_src_i;   end
  initial begin #0.25; forever #3  sdram_src_i = ~sdram_src_i; end
  initial begin #0.25; forever #7  ref_src_i   = ~ref_src_i;   end
  initial begin #0.25; forever #5  clk48_src_i = ~clk48_src_i; end
  initial begin #0.25; forever #10 clk24_src_i = ~clk24_src_i; end

  // R8 monitor: high pulse widths
  always @(posedge cpu_clk_o) t_cpu_r = $realtime;
  always @(negedge cpu_clk_o) if ($realtime - t_cpu_r < 1.9) runt++;
  always @(posedge pci_clk_o[0]) t_pci_r = $realtime;
  always @(negedge pci_clk_o[0]) if ($realtime - t_pci_r < 5.9) runt++;
  always @(posedge mid_clk_o) mid_cnt++;

  // [30:15] stim {pd,stop,cpu,pci6,sd3,usb,mid,ref2}; [14:0] seen {cpu,cs,pci6,sd3,usb,mid,ref1,ref0}
  localparam logic [30:0] VEC [5] = '{
    {1'b1,1'b1,1'b1,6'h3f,3'h7,1'b1,1'b1,2'b11, 1'b1,1'b1,6'h3f,3'h7,1'b1,1'b1,1'b1,1'b0},
    {1'b1,1'b0,1'b1,6'h3f,3'h7,1'b1,1'b1,2'b11, 1'b0,1'b0,6'h3f,3'h7,1'b1,1'b1,1'b1,1'b0},
    {1'b0,1'b1,1'b1,6'h3f,3'h7,1'b1,1'b1,2'b11, 15'h0},
    {1'b1,1'b1,1'b1,6'h2a,3'h2,1'b0,1'b1,2'b01, 1'b1,1'b1,6'h2a,3'h2,1'b0,1'b1,1'b0,1'b0},
    {1'b1,1'b1,1'b0,6'h15,3'h5,1'b1,1'b0,2'b10, 1'b0,1'b0,6'h15,3'h5,1'b1,1'b0,1'b1,1'b0}
  };

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic watch(output logic [14:0] seen);
    seen = '0;
    repeat (200) begin
      #1;
      seen |= {cpu_clk_o, chipset_clk_o, pci_clk_o, sdram_clk_o[8], sdram_clk_o[4],
               sdram_clk_o[0], usb_clk_o, mid_clk_o, ref_clk_o};
    end
  endtask

  task automatic release_reset();
    @(negedge clk_i) rst_ni = 1'b1;
    repeat (4) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin
    #300us;
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [14:0] seen;
    #12;
    chk(freq_code_o == 4'h0 && mode_o == 1'b0, "R11 reset code/mode", {freq_code_o, 3'b0, mode_o}, 0);
    chk({cpu_clk_o, pci_clk_o, sdram_clk_o, ref_clk_o, mid_clk_o} == '0, "R11 reset clocks low",
        {cpu_clk_o, pci_clk_o, sdram_clk_o, ref_clk_o, mid_clk_o}, 0);
    chk(strap_oe_o == 1'b0, "R10 oe in reset", strap_oe_o, 0);
    @(negedge clk_i) rst_ni = 1'b1;
    @(posedge clk_i) #1;
    chk(strap_oe_o == 1'b1, "R10 oe after capture", strap_oe_o, 1);
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk(freq_code_o == 4'b1010, "R2 strap code selected", freq_code_o, 4'b1010);
    chk(mode_o == 1'b0, "R1 mode captured", mode_o, 0);
    strap_fs_i = 4'b0101; strap_mode_i = 1'b1;
    repeat (5) @(negedge clk_i);
    chk(freq_code_o == 4'b1010 && mode_o == 1'b0, "R1 straps ignored after capture",
        {freq_code_o, mode_o}, {4'b1010, 1'b0});

    // table: R4 R5 R6 R7 in mode 0
    for (int k = 0; k < 5; k++) begin
      @(negedge clk_i);
      {pd_ni, cpu_stop_ni, cpu_en_i, pci_en_i, sdram_en_i, usb_en_i, mid_en_i, ref_en_i} = VEC[k][30:15];
      #30;
      watch(seen);
      chk(seen == VEC[k][14:0], $sformatf("R4 R5 R6 R7 vector %0d", k), seen, VEC[k][14:0]);
    end
    @(negedge clk_i);
    {pd_ni, cpu_stop_ni, cpu_en_i, pci_en_i, sdram_en_i, usb_en_i, mid_en_i, ref_en_i} = VEC[0][30:15];
    chk(ref0_oe_o == 1'b0, "R6 ref0 pin is input in mode 0", ref0_oe_o, 0);
    #40;

    // R8: power down inside a high phase completes it
    @(posedge cpu_src_i) #0.5 pd_ni = 1'b0;
    #0.75;
    chk(cpu_clk_o == 1'b1, "R8 high phase kept", cpu_clk_o, 1);
    #3.5;
    chk(cpu_clk_o == 1'b0, "R7 held low after stop", cpu_clk_o, 0);
    @(negedge clk_i) pd_ni = 1'b1;
    #40;

    // R9 shared pin source
    @(negedge clk_i) sel48_i = 1'b1;
    #40 mid_cnt = 0;
    #200;
    chk(mid_cnt >= 19 && mid_cnt <= 21, "R9 48 MHz on shared pin", mid_cnt, 20);
    @(negedge clk_i) sel48_i = 1'b0;
    #40 mid_cnt = 0;
    #200;
    chk(mid_cnt >= 9 && mid_cnt <= 11, "R9 24 MHz on shared pin", mid_cnt, 10);

    // R2 R3 software code {bit2, bits6:4}
    @(negedge clk_i) freq_ctl_i = 8'b0011_1100;
    @(posedge clk_i) #1;
    chk(freq_code_o == 4'b1010, "R3 not yet after one edge", freq_code_o, 4'b1010);
    @(posedge clk_i) #1;
    chk(freq_code_o == 4'b1011, "R2 R3 software code", freq_code_o, 4'b1011);
    @(negedge clk_i) freq_ctl_i = 8'b0000_1000;
    @(negedge clk_i) freq_ctl_i = 8'b0011_1100;
    repeat (4) @(negedge clk_i);
    chk(freq_code_o == 4'b1011, "R3 one-cycle code filtered", freq_code_o, 4'b1011);

    // mode 1
    @(negedge clk_i) rst_ni = 1'b0;
    strap_mode_i = 1'b1; strap_fs_i = 4'b0110; freq_ctl_i = 8'h00;
    #20;
    release_reset();
    chk(freq_code_o == 4'b0110 && mode_o == 1'b1, "R1 R2 mode 1 straps", {freq_code_o, mode_o}, {4'b0110, 1'b1});
    chk(ref0_oe_o == 1'b1, "R6 ref0 driven in mode 1", ref0_oe_o, 1);
    cpu_stop_ni = 1'b0;
    #30;
    watch(seen);
    chk(seen == 15'h7fff, "R5 R6 stop ignored, ref0 runs in mode 1", seen, 15'h7fff);
    chk(runt == 0, "R8 no short high pulse", runt, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule